// File: doc/BRIEF.md
# Per-Port Source Address Watch

This block watches the source address of every frame that finishes on one of a set of ports. It keeps two 48-bit addresses per port. The first is a learned address that follows the most recent good sender. The second is a programmed authorised address. At the end of each frame, an upstream parser presents a one-beat record on a valid/ready stream. The record holds the port number, the source address and a flag that says whether the frame was good. The block compares the address with both stored values. It then sets sticky event bits and drives one shared interrupt line.

Two events exist for each port. An address-change event fires when a good frame's address differs from the learned address, or from the authorised address once that address has been programmed. An intruder event fires only on a difference from the authorised address. The learned address follows a good, differing frame unless that port's lock input is high. Software programs both stored addresses through a simple write port and reads them back through a port-indexed read mux. Event bits stay set until software writes 1 to clear them. Each event class has its own per-port interrupt enable.

The record stream never applies back-pressure: `fr_ready` is held high, so a record is taken on every cycle in which `fr_valid` is high. An upstream source may therefore present one record per cycle, with no wait state.

Top module: `srcaddr_guard`

## Requirements
- R1: After reset, all event status bits are 0, `irq` is 0, every learned and authorised address reads 0, and every port reads `rd_pref_ok` = 0.
- R2: A record on an unlocked port with `fr_good`=1 and an address different from that port's learned address has two effects, both visible after the accepting clock edge. The learned address takes the new value, and that port's bit in `chg_status` is set.
- R3: A good record whose address equals both the learned address and, when programmed, the authorised address sets no status bit and leaves both addresses unchanged.
- R4: A record with `fr_good`=0 has no effect. No address changes and no status bit is set.
- R5: While `cfg_lock[p]` is 1, good records never change port p's learned address. A differing address still sets `chg_status[p]`.
- R6: Once port p's authorised address is programmed, a good record whose address differs from it sets both `intr_status[p]` and `chg_status[p]`.
- R7: Writing the authorised address (`cfg_sel`=1) sets that port's `rd_pref_ok`. Until then, no intruder event is raised for that port.
- R8: A good record that matches the learned address but differs from a programmed authorised address sets `chg_status[p]`.
- R9: Status bits are sticky. A 1 in `clr_chg` or `clr_intr` clears the matching bit on the next edge. A new event in the same cycle overrides the clear.
- R10: `irq` is high exactly when some port has a status bit set whose matching enable bit (`chg_en` or `intr_en`) is 1. An enable of 0 masks the interrupt but not the status bit.
- R11: A record for port p changes no address and no status bit of any other port.
- R12: `fr_ready` is always 1 out of reset, so every cycle with `fr_valid` high is one accepted record.
- R13: A configuration write to the learned address (`cfg_sel`=0) wins over a learning update to the same port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fr_valid | input | 1 | End-of-frame record valid |
| fr_ready | output | 1 | Record accepted (constant 1) |
| fr_port | input | PORT_W | Port that received the frame |
| fr_good | input | 1 | Frame passed upstream checks |
| fr_addr | input | ADDR_W | Source address of the frame |
| cfg_we | input | 1 | Address write strobe |
| cfg_sel | input | 1 | 0 = learned address, 1 = authorised address |
| cfg_port | input | PORT_W | Port targeted by the write |
| cfg_addr | input | ADDR_W | Value to write |
| cfg_lock | input | NUM_PORTS | Per-port learning lock |
| chg_en | input | NUM_PORTS | Address-change interrupt enables |
| intr_en | input | NUM_PORTS | Intruder interrupt enables |
| clr_chg | input | NUM_PORTS | Write-1-to-clear for `chg_status` |
| clr_intr | input | NUM_PORTS | Write-1-to-clear for `intr_status` |
| chg_status | output | NUM_PORTS | Sticky address-change events |
| intr_status | output | NUM_PORTS | Sticky intruder events |
| irq | output | 1 | Shared interrupt |
| rd_port | input | PORT_W | Port selected for read-back |
| rd_last | output | ADDR_W | Learned address of `rd_port` |
| rd_pref | output | ADDR_W | Authorised address of `rd_port` |
| rd_pref_ok | output | 1 | Authorised address of `rd_port` has been programmed |

## Verification
Every result of an accepted record or a configuration write is registered once. The result shows on the status outputs and the read-back mux after the single clock edge that accepts it, and `irq` follows the status bits combinationally in that same cycle. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then samples one nanosecond later, so each check reads the state after exactly one rising edge. Clears follow the same one-edge rule. The set-over-clear case and the write-over-learn case are built by placing both stimuli in the same driven cycle.

// File: rtl/sag_pkg.sv
package sag_pkg;
  // Target of a configuration write
  typedef enum logic {
    SEL_LAST = 1'b0,
    SEL_PREF = 1'b1
  } cfg_sel_t;

  // Per-port event pair produced by a comparison
  typedef struct packed {
    logic chg;
    logic intr;
  } sag_event_t;
endpackage

// File: rtl/sag_port_slot.sv
module sag_port_slot #(
  parameter int ADDR_W = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hit,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   lock,
  input  logic                   wr_last,
  input  logic                   wr_pref,
  input  logic [ADDR_W-1:0]      wr_addr,
  output logic [ADDR_W-1:0]      last_q,
  output logic [ADDR_W-1:0]      pref_q,
  output logic                   pref_ok,
  output sag_pkg::sag_event_t    ev
);
  logic mism_last;
  logic mism_pref;

  always_comb begin
    mism_last = (addr != last_q);
    mism_pref = pref_ok && (addr != pref_q);
    ev.chg    = hit && (mism_last || mism_pref);
    ev.intr   = hit && mism_pref;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      pref_q  <= '0;
      pref_ok <= 1'b0;
    end else begin
      if (wr_last)
        last_q <= wr_addr;
      else if (hit && !lock && mism_last)
        last_q <= addr;
      if (wr_pref) begin
        pref_q  <= wr_addr;
        pref_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sag_irq_ctrl.sv
module sag_irq_ctrl #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] ev_chg,
  input  logic [NUM_PORTS-1:0] ev_intr,
  input  logic [NUM_PORTS-1:0] clr_chg,
  input  logic [NUM_PORTS-1:0] clr_intr,
  input  logic [NUM_PORTS-1:0] chg_en,
  input  logic [NUM_PORTS-1:0] intr_en,
  output logic [NUM_PORTS-1:0] chg_status,
  output logic [NUM_PORTS-1:0] intr_status,
  output logic                 irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_status  <= '0;
      intr_status <= '0;
    end else begin
      // a fresh event overrides a clear in the same cycle
      chg_status  <= (chg_status  & ~clr_chg)  | ev_chg;
      intr_status <= (intr_status & ~clr_intr) | ev_intr;
    end
  end

  assign irq = |((chg_status & chg_en) | (intr_status & intr_en));
endmodule

// File: rtl/srcaddr_guard.sv
module srcaddr_guard #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 48,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fr_valid,
  output logic                 fr_ready,
  input  logic [PORT_W-1:0]    fr_port,
  input  logic                 fr_good,
  input  logic [ADDR_W-1:0]    fr_addr,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [NUM_PORTS-1:0] cfg_lock,
  input  logic [NUM_PORTS-1:0] chg_en,
  input  logic [NUM_PORTS-1:0] intr_en,
  input  logic [NUM_PORTS-1:0] clr_chg,
  input  logic [NUM_PORTS-1:0] clr_intr,
  output logic [NUM_PORTS-1:0] chg_status,
  output logic [NUM_PORTS-1:0] intr_status,
  output logic                 irq,
  input  logic [PORT_W-1:0]    rd_port,
  output logic [ADDR_W-1:0]    rd_last,
  output logic [ADDR_W-1:0]    rd_pref,
  output logic                 rd_pref_ok
);
  import sag_pkg::*;

  logic [NUM_PORTS-1:0][ADDR_W-1:0] last_all;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] pref_all;
  logic [NUM_PORTS-1:0]             pref_ok_all;
  logic [NUM_PORTS-1:0]             ev_chg;
  logic [NUM_PORTS-1:0]             ev_intr;

  // The record stream is never stalled
  assign fr_ready = 1'b1;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic       hit;
    logic       wr_last;
    logic       wr_pref;
    sag_event_t ev;

    assign hit     = fr_valid && fr_good && (fr_port == PORT_W'(i));
    assign wr_last = cfg_we && (cfg_port == PORT_W'(i)) && (cfg_sel == SEL_LAST);
    assign wr_pref = cfg_we && (cfg_port == PORT_W'(i)) && (cfg_sel == SEL_PREF);

    sag_port_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .addr    (fr_addr),
      .lock    (cfg_lock[i]),
      .wr_last (wr_last),
      .wr_pref (wr_pref),
      .wr_addr (cfg_addr),
      .last_q  (last_all[i]),
      .pref_q  (pref_all[i]),
      .pref_ok (pref_ok_all[i]),
      .ev      (ev)
    );

    assign ev_chg[i]  = ev.chg;
    assign ev_intr[i] = ev.intr;
  end

  sag_irq_ctrl #(.NUM_PORTS(NUM_PORTS)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_chg      (ev_chg),
    .ev_intr     (ev_intr),
    .clr_chg     (clr_chg),
    .clr_intr    (clr_intr),
    .chg_en      (chg_en),
    .intr_en     (intr_en),
    .chg_status  (chg_status),
    .intr_status (intr_status),
    .irq         (irq)
  );

  assign rd_last    = last_all[rd_port];
  assign rd_pref    = pref_all[rd_port];
  assign rd_pref_ok = pref_ok_all[rd_port];
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 48,
  parameter int PORT_W    = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             fr_valid,
  input logic                             fr_ready,
  input logic [PORT_W-1:0]                fr_port,
  input logic                             fr_good,
  input logic [ADDR_W-1:0]                fr_addr,
  input logic                             cfg_we,
  input logic [PORT_W-1:0]                cfg_port,
  input logic [NUM_PORTS-1:0]             cfg_lock,
  input logic [NUM_PORTS-1:0]             clr_chg,
  input logic [NUM_PORTS-1:0]             chg_status,
  input logic [NUM_PORTS-1:0]             intr_status,
  input logic                             irq,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] last_all
);
  // R12: the stream never stalls
  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n) fr_ready);

  // R2: an unlocked good record is learned on the next edge
  p_learn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_good && !cfg_lock[fr_port] && !(cfg_we && cfg_port == fr_port))
    |=> last_all[$past(fr_port)] == $past(fr_addr));

  // R4: a bad record, with no write pending, touches nothing
  p_bad_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_good && !cfg_we)
    |=> ($stable(last_all) && ((chg_status & ~$past(chg_status)) == '0)));

  // R5: a locked port keeps its learned address
  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && cfg_lock[fr_port] && !cfg_we) |=> $stable(last_all));

  // R9: status bits fall only when cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(chg_status) & ~$past(clr_chg) & ~chg_status) == '0));

  // R6: every new intruder bit comes with an address-change bit
  p_intr_with_chg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((intr_status & ~$past(intr_status)) & ~chg_status) == '0));

  // R10: no status, no interrupt
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_status == '0 && intr_status == '0) |-> !irq);
endmodule

bind srcaddr_guard sag_checker #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PORT_W(PORT_W)
) u_sag_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .fr_valid    (fr_valid),
  .fr_ready    (fr_ready),
  .fr_port     (fr_port),
  .fr_good     (fr_good),
  .fr_addr     (fr_addr),
  .cfg_we      (cfg_we),
  .cfg_port    (cfg_port),
  .cfg_lock    (cfg_lock),
  .clr_chg     (clr_chg),
  .chg_status  (chg_status),
  .intr_status (intr_status),
  .irq         (irq),
  .last_all    (last_all)
);

// File: tb/srcaddr_guard_tb_top.sv
`timescale 1ns/1ps
module srcaddr_guard_tb_top;
  localparam int NP = 4;
  localparam int AW = 48;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fr_valid = 1'b0;
  logic          fr_ready;
  logic [PW-1:0] fr_port = '0;
  logic          fr_good = 1'b0;
  logic [AW-1:0] fr_addr = '0;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [PW-1:0] cfg_port = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [NP-1:0] cfg_lock = '0;
  logic [NP-1:0] chg_en = '0;
  logic [NP-1:0] intr_en = '0;
  logic [NP-1:0] clr_chg = '0;
  logic [NP-1:0] clr_intr = '0;
  logic [NP-1:0] chg_status;
  logic [NP-1:0] intr_status;
  logic          irq;
  logic [PW-1:0] rd_port = '0;
  logic [AW-1:0] rd_last;
  logic [AW-1:0] rd_pref;
  logic          rd_pref_ok;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  srcaddr_guard #(.NUM_PORTS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_ready(fr_ready),
    .fr_port(fr_port), .fr_good(fr_good), .fr_addr(fr_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_port(cfg_port), .cfg_addr(cfg_addr),
    .cfg_lock(cfg_lock), .chg_en(chg_en), .intr_en(intr_en),
    .clr_chg(clr_chg), .clr_intr(clr_intr), .chg_status(chg_status),
    .intr_status(intr_status), .irq(irq), .rd_port(rd_port),
    .rd_last(rd_last), .rd_pref(rd_pref), .rd_pref_ok(rd_pref_ok)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one record, one edge, then sample
  task automatic send(logic [PW-1:0] p, logic [AW-1:0] a, logic good);
    @(negedge clk);
    fr_valid = 1'b1; fr_port = p; fr_addr = a; fr_good = good;
    @(negedge clk);
    fr_valid = 1'b0; fr_good = 1'b0;
    #1;
  endtask

  task automatic cfg_write(logic sel, logic [PW-1:0] p, logic [AW-1:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_port = p; cfg_addr = a;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_chg = '1; clr_intr = '1;
    @(negedge clk);
    clr_chg = '0; clr_intr = '0;
    #1;
  endtask

  task automatic read_last(logic [PW-1:0] p, output logic [AW-1:0] v);
    rd_port = p; #1; v = rd_last;
  endtask

  task automatic t_reset();
    logic [AW-1:0] v;
    check("R1 chg_status", chg_status, 0);
    check("R1 intr_status", intr_status, 0);
    check("R1 irq", irq, 0);
    for (int p = 0; p < NP; p++) begin
      rd_port = PW'(p); #1;
      check("R1 rd_last", rd_last, 0);
      check("R1 rd_pref", rd_pref, 0);
      check("R1 rd_pref_ok", rd_pref_ok, 0);
    end
    read_last(0, v);
  endtask

  task automatic t_learn();
    logic [AW-1:0] v;
    check("R12 fr_ready", fr_ready, 1);
    send(1, 48'h0A1B2C3D4E5F, 1'b1);
    read_last(1, v);
    check("R2 learned", v, 48'h0A1B2C3D4E5F);
    check("R2 chg bit", chg_status, 4'b0010);
    check("R7 no intr before prog", intr_status, 0);
    check("R10 masked irq", irq, 0);
    chg_en = 4'b0010; #1;
    check("R10 enabled irq", irq, 1);
    clear_all();
    check("R9 cleared", chg_status, 0);
    check("R10 irq after clear", irq, 0);
    chg_en = '0;
  endtask

  task automatic t_repeat();
    logic [AW-1:0] v;
    send(1, 48'h0A1B2C3D4E5F, 1'b1);
    check("R3 no event", chg_status, 0);
    read_last(1, v);
    check("R3 last kept", v, 48'h0A1B2C3D4E5F);
  endtask

  task automatic t_invalid();
    logic [AW-1:0] v;
    send(1, 48'h111122223333, 1'b0);
    read_last(1, v);
    check("R4 last kept", v, 48'h0A1B2C3D4E5F);
    check("R4 no chg", chg_status, 0);
    check("R4 no intr", intr_status, 0);
  endtask

  task automatic t_lock();
    logic [AW-1:0] v;
    cfg_lock = 4'b0010;
    send(1, 48'h444455556666, 1'b1);
    read_last(1, v);
    check("R5 locked last", v, 48'h0A1B2C3D4E5F);
    check("R5 chg still set", chg_status, 4'b0010);
    cfg_lock = '0;
    clear_all();
  endtask

  task automatic t_intruder();
    logic [AW-1:0] v;
    check("R12 fr_ready idle", fr_ready, 1);
    cfg_write(1'b1, 2, 48'hAAAA0000BBBB);
    rd_port = 2; #1;
    check("R7 pref_ok", rd_pref_ok, 1);
    check("R7 pref value", rd_pref, 48'hAAAA0000BBBB);
    send(2, 48'hAAAA0000BBBB, 1'b1);
    check("R2 chg from last", chg_status, 4'b0100);
    check("R6 no intr on match", intr_status, 0);
    clear_all();
    intr_en = 4'b0100;
    send(2, 48'hDEADBEEF0001, 1'b1);
    check("R6 intr set", intr_status, 4'b0100);
    check("R6 chg set", chg_status, 4'b0100);
    check("R10 intr irq", irq, 1);
    clear_all();
    send(2, 48'hAAAA0000BBBB, 1'b1);
    check("R2 relearn chg", chg_status, 4'b0100);
    check("R6 no intr back on pref", intr_status, 0);
    clear_all();
    send(2, 48'hAAAA0000BBBB, 1'b1);
    check("R3 both match chg", chg_status, 0);
    check("R3 both match intr", intr_status, 0);
    read_last(2, v);
    check("R3 last", v, 48'hAAAA0000BBBB);
    intr_en = '0;
  endtask

  task automatic t_pref_mismatch();
    logic [AW-1:0] v;
    cfg_write(1'b1, 3, 48'h0000CAFE0000);
    cfg_write(1'b0, 3, 48'h123456789ABC);
    read_last(3, v);
    check("R13 cfg write last", v, 48'h123456789ABC);
    send(3, 48'h123456789ABC, 1'b1);
    check("R8 chg via pref", chg_status, 4'b1000);
    check("R6 intr via pref", intr_status, 4'b1000);
    read_last(3, v);
    check("R8 last kept", v, 48'h123456789ABC);
    clear_all();
  endtask

  task automatic t_isolation();
    logic [AW-1:0] v;
    send(0, 48'h00000000BEEF, 1'b1);
    check("R11 only port0 chg", chg_status, 4'b0001);
    check("R11 no intr", intr_status, 0);
    read_last(1, v);
    check("R11 port1 last", v, 48'h0A1B2C3D4E5F);
    read_last(2, v);
    check("R11 port2 last", v, 48'hAAAA0000BBBB);
  endtask

  task automatic t_set_wins();
    // chg_status[0] is set here; clear it while a new event arrives
    @(negedge clk);
    fr_valid = 1'b1; fr_port = 0; fr_addr = 48'h00000000F00D; fr_good = 1'b1;
    clr_chg = 4'b0001;
    @(negedge clk);
    fr_valid = 1'b0; fr_good = 1'b0; clr_chg = '0;
    #1;
    check("R9 set beats clear", chg_status, 4'b0001);
    clear_all();
    check("R9 clear alone", chg_status, 0);
  endtask

  task automatic t_cfg_priority();
    logic [AW-1:0] v;
    @(negedge clk);
    fr_valid = 1'b1; fr_port = 0; fr_addr = 48'h777777777777; fr_good = 1'b1;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_port = 0; cfg_addr = 48'h999999999999;
    @(negedge clk);
    fr_valid = 1'b0; fr_good = 1'b0; cfg_we = 1'b0;
    #1;
    read_last(0, v);
    check("R13 write beats learn", v, 48'h999999999999);
    clear_all();
  endtask

  bit done = 1'b0;

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_learn();
    t_repeat();
    t_invalid();
    t_lock();
    t_intruder();
    t_pref_mismatch();
    t_isolation();
    t_set_wins();
    t_cfg_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule